// File: doc/BRIEF.md
# Pipeline Forwarding and Interlock Unit

This block is the hazard logic for a five-stage integer pipeline with stages fetch, decode, execute, memory and write-back. It has no clock and no state. Each cycle it compares the source register fields of the instructions in decode and execute with the destination fields held in the two later pipeline registers. From that comparison it drives the bypass multiplexer selects in the datapath. It covers both ALU operands, the store-data input of the data memory, and a zero detector in decode that resolves branch-on-zero.

When a needed value cannot be forwarded in time, the unit inserts one bubble. It holds the PC and the fetch/decode register, and it tells the pipeline to load a no-op control word into the decode/execute register. Two cases need this bubble. The first is a load followed directly by an ALU use of its result. The second is a decode-stage branch whose tested register is still being computed in execute, or is still being loaded in memory.

Two elaboration options pick variants. The first enables the decode-stage zero detector and its interlocks. The second enables forwarding of loaded data into the store input. The register file, the memories and the datapath muxes themselves sit outside this block.

Top module: `hazard_bypass_unit`

## Requirements
- R1: Each ALU operand select (`fwd_a_sel` for the execute instruction's first source, `fwd_b_sel` for its second) gives code 1 when that source is in use, is non-zero, and equals the destination of a writing instruction in the memory stage.
- R2: If the memory stage does not match but the write-back stage has a writing instruction with that destination, the operand select gives code 2, whether that instruction is an ALU operation or a load. With no match the select is code 0, the register file. Code 3 never appears.
- R3: When both the memory stage and the write-back stage write the same source register, the operand select picks the younger result, code 1.
- R4: Register index 0 never causes forwarding or a stall. A destination without its write-enable, or a source not flagged as used, also never causes forwarding or a stall.
- R5: `st_data_sel` is 1 when the store now in the memory stage has a data register that is non-zero and equals the destination written by the write-back instruction. A load followed directly by a store of the loaded register, used only as store data, causes no stall.
- R6: `zero_sel` drives the decode-stage zero detector for a branch, using the same codes as R1 and R2. Code 1 is used only for a non-load writer in the memory stage. Code 2 is used for any writer in the write-back stage.
- R7: A load in execute whose destination is a used ALU source (first or second) of the decode instruction raises `hold_pc_ifid` and `flush_idex` for that cycle.
- R8: A decode branch stalls when its tested register is written by any instruction in execute, or by a load in the memory stage.
- R9: A non-load writer in execute that matches a decode source does not stall an ALU instruction, because the operand is forwarded one cycle later.
- R10: `hold_pc_ifid` and `flush_idex` are always equal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| id_rs1 | input | IDX_W | Decode first source index (also the branch test register) |
| id_rs2 | input | IDX_W | Decode second source index |
| id_use_a | input | 1 | Decode first source feeds the ALU |
| id_use_b | input | 1 | Decode second source is read (ALU operand or store data) |
| id_store | input | 1 | Decode instruction is a store (second source is data only) |
| id_branch | input | 1 | Decode instruction is a branch-on-zero testing the first source |
| ex_rs1 | input | IDX_W | Execute first source index |
| ex_rs2 | input | IDX_W | Execute second source index |
| ex_use_a | input | 1 | Execute first source is read |
| ex_use_b | input | 1 | Execute second source is read |
| ex_rd | input | IDX_W | Execute destination index |
| ex_wen | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a load |
| mem_rs2 | input | IDX_W | Memory-stage store data register index |
| mem_store | input | 1 | Memory-stage instruction is a store |
| mem_rd | input | IDX_W | Memory-stage destination index |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| mem_load | input | 1 | Memory-stage instruction is a load |
| wb_rd | input | IDX_W | Write-back destination index |
| wb_wen | input | 1 | Write-back instruction writes a register |
| fwd_a_sel | output | 2 | First ALU operand source: 0 file, 1 mem-stage result, 2 write-back value |
| fwd_b_sel | output | 2 | Second ALU operand source, same codes |
| st_data_sel | output | 1 | 1: store data taken from the write-back value |
| zero_sel | output | 2 | Zero detector source, same codes |
| hold_pc_ifid | output | 1 | Hold PC and fetch/decode register |
| flush_idex | output | 1 | Load a no-op into decode/execute |

## Verification
Every evaluation checks several invariants. The unit never selects a bypass from register 0. Code 1 always names a memory-stage writer whose destination matches the source. The zero detector never takes code 1 while the memory stage holds a load. Store forwarding names a matching write-back writer. The hold and flush outputs always agree. The directed scenarios are needed for the remaining behaviour: the priority of the younger result over the older one, the exact conditions under which a bubble appears, and the absence of a stall for a forwardable ALU producer or for a store of freshly loaded data.

// File: rtl/hzu_pkg.sv
package hzu_pkg;
   // Bypass source codes shared by all select outputs
   typedef enum logic [1:0] {
      SRC_RF    = 2'd0,
      SRC_EXMEM = 2'd1,
      SRC_MEMWB = 2'd2
   } src_e;

   localparam int unsigned MAX_IDX_W = 8;
endpackage

// File: rtl/hzu_match.sv
// One producer/consumer comparison; index 0 never hits.
module hzu_match #(
   parameter int unsigned IDX_W = 5
) (
   input  logic [IDX_W-1:0] src,
   input  logic             src_used,
   input  logic [IDX_W-1:0] dst,
   input  logic             dst_wen,
   output logic             hit
);
   logic dst_live;

   always_comb begin
      dst_live = dst_wen && (dst != '0);
      hit      = src_used && dst_live && (dst == src);
   end
endmodule

// File: rtl/hzu_pick.sv
// Priority bypass choice for one consumer: younger memory-stage result first.
module hzu_pick #(
   parameter int unsigned IDX_W = 5
) (
   input  logic [IDX_W-1:0] src,
   input  logic             src_used,
   input  logic [IDX_W-1:0] near_rd,
   input  logic             near_wen,
   input  logic [IDX_W-1:0] far_rd,
   input  logic             far_wen,
   output hzu_pkg::src_e    sel
);
   logic near_hit;
   logic far_hit;

   hzu_match #(.IDX_W(IDX_W)) u_near (
      .src(src), .src_used(src_used), .dst(near_rd), .dst_wen(near_wen), .hit(near_hit)
   );

   hzu_match #(.IDX_W(IDX_W)) u_far (
      .src(src), .src_used(src_used), .dst(far_rd), .dst_wen(far_wen), .hit(far_hit)
   );

   always_comb begin
      if (near_hit)     sel = hzu_pkg::SRC_EXMEM;
      else if (far_hit) sel = hzu_pkg::SRC_MEMWB;
      else              sel = hzu_pkg::SRC_RF;
   end
endmodule

// File: rtl/hzu_interlock.sv
// Bubble request for hazards that forwarding cannot cover.
module hzu_interlock #(
   parameter int unsigned IDX_W         = 5,
   parameter bit          DECODE_BRANCH = 1'b1,
   parameter bit          MEM_STORE_FWD = 1'b1
) (
   input  logic [IDX_W-1:0] id_rs1,
   input  logic [IDX_W-1:0] id_rs2,
   input  logic             id_use_a,
   input  logic             id_use_b,
   input  logic             id_store,
   input  logic             id_branch,
   input  logic [IDX_W-1:0] ex_rd,
   input  logic             ex_wen,
   input  logic             ex_load,
   input  logic [IDX_W-1:0] mem_rd,
   input  logic             mem_wen,
   input  logic             mem_load,
   output logic             stall
);
   logic ld_wen;
   logic use_a_alu;
   logic use_b_alu;
   logic ld_hit_a;
   logic ld_hit_b;
   logic br_stall;

   always_comb begin
      ld_wen    = ex_wen && ex_load;
      use_a_alu = id_use_a && !(DECODE_BRANCH && id_branch);
      // Store data alone waits for the memory-stage bypass when enabled
      use_b_alu = id_use_b && !(MEM_STORE_FWD && id_store);
   end

   hzu_match #(.IDX_W(IDX_W)) u_ld_a (
      .src(id_rs1), .src_used(use_a_alu), .dst(ex_rd), .dst_wen(ld_wen), .hit(ld_hit_a)
   );

   hzu_match #(.IDX_W(IDX_W)) u_ld_b (
      .src(id_rs2), .src_used(use_b_alu), .dst(ex_rd), .dst_wen(ld_wen), .hit(ld_hit_b)
   );

   generate
      if (DECODE_BRANCH) begin : g_br
         logic br_ex_hit;
         logic br_mem_hit;
         logic mem_ld_wen;

         assign mem_ld_wen = mem_wen && mem_load;

         hzu_match #(.IDX_W(IDX_W)) u_br_ex (
            .src(id_rs1), .src_used(id_branch), .dst(ex_rd), .dst_wen(ex_wen), .hit(br_ex_hit)
         );

         hzu_match #(.IDX_W(IDX_W)) u_br_mem (
            .src(id_rs1), .src_used(id_branch), .dst(mem_rd), .dst_wen(mem_ld_wen), .hit(br_mem_hit)
         );

         assign br_stall = br_ex_hit || br_mem_hit;
      end else begin : g_no_br
         logic unused_br;
         assign unused_br = id_branch ^ mem_wen ^ mem_load ^ (^mem_rd);
         assign br_stall  = 1'b0;
      end
   endgenerate

   assign stall = ld_hit_a || ld_hit_b || br_stall;
endmodule

// File: rtl/hazard_bypass_unit.sv
module hazard_bypass_unit #(
   parameter int unsigned IDX_W         = 5,
   parameter bit          DECODE_BRANCH = 1'b1,
   parameter bit          MEM_STORE_FWD = 1'b1
) (
   input  logic [IDX_W-1:0] id_rs1,
   input  logic [IDX_W-1:0] id_rs2,
   input  logic             id_use_a,
   input  logic             id_use_b,
   input  logic             id_store,
   input  logic             id_branch,
   input  logic [IDX_W-1:0] ex_rs1,
   input  logic [IDX_W-1:0] ex_rs2,
   input  logic             ex_use_a,
   input  logic             ex_use_b,
   input  logic [IDX_W-1:0] ex_rd,
   input  logic             ex_wen,
   input  logic             ex_load,
   input  logic [IDX_W-1:0] mem_rs2,
   input  logic             mem_store,
   input  logic [IDX_W-1:0] mem_rd,
   input  logic             mem_wen,
   input  logic             mem_load,
   input  logic [IDX_W-1:0] wb_rd,
   input  logic             wb_wen,
   output logic [1:0]       fwd_a_sel,
   output logic [1:0]       fwd_b_sel,
   output logic             st_data_sel,
   output logic [1:0]       zero_sel,
   output logic             hold_pc_ifid,
   output logic             flush_idex
);
   localparam int unsigned N_OPS = 2;

   generate
      if (IDX_W < 1 || IDX_W > hzu_pkg::MAX_IDX_W) begin : g_bad_w
         $error("hazard_bypass_unit: IDX_W out of range");
      end
   endgenerate

   logic [IDX_W-1:0] op_src  [N_OPS];
   logic             op_used [N_OPS];
   hzu_pkg::src_e    op_sel  [N_OPS];

   assign op_src[0]  = ex_rs1;
   assign op_src[1]  = ex_rs2;
   assign op_used[0] = ex_use_a;
   assign op_used[1] = ex_use_b;

   genvar k;
   generate
      for (k = 0; k < N_OPS; k++) begin : g_op
         hzu_pick #(.IDX_W(IDX_W)) u_pick (
            .src(op_src[k]), .src_used(op_used[k]),
            .near_rd(mem_rd), .near_wen(mem_wen),
            .far_rd(wb_rd), .far_wen(wb_wen),
            .sel(op_sel[k])
         );
      end
   endgenerate

   assign fwd_a_sel = op_sel[0];
   assign fwd_b_sel = op_sel[1];

   // Zero detector bypass in decode
   generate
      if (DECODE_BRANCH) begin : g_zero
         hzu_pkg::src_e z_sel;
         logic          mem_alu_wen;
         assign mem_alu_wen = mem_wen && !mem_load;
         hzu_pick #(.IDX_W(IDX_W)) u_zpick (
            .src(id_rs1), .src_used(id_branch),
            .near_rd(mem_rd), .near_wen(mem_alu_wen),
            .far_rd(wb_rd), .far_wen(wb_wen),
            .sel(z_sel)
         );
         assign zero_sel = z_sel;
      end else begin : g_no_zero
         assign zero_sel = hzu_pkg::SRC_RF;
      end
   endgenerate

   // Store data bypass in the memory stage
   generate
      if (MEM_STORE_FWD) begin : g_st
         hzu_match #(.IDX_W(IDX_W)) u_st (
            .src(mem_rs2), .src_used(mem_store), .dst(wb_rd), .dst_wen(wb_wen), .hit(st_data_sel)
         );
      end else begin : g_no_st
         logic unused_st;
         assign unused_st   = mem_store ^ (^mem_rs2);
         assign st_data_sel = 1'b0;
      end
   endgenerate

   logic stall;

   hzu_interlock #(
      .IDX_W(IDX_W), .DECODE_BRANCH(DECODE_BRANCH), .MEM_STORE_FWD(MEM_STORE_FWD)
   ) u_lock (
      .id_rs1(id_rs1), .id_rs2(id_rs2), .id_use_a(id_use_a), .id_use_b(id_use_b),
      .id_store(id_store), .id_branch(id_branch),
      .ex_rd(ex_rd), .ex_wen(ex_wen), .ex_load(ex_load),
      .mem_rd(mem_rd), .mem_wen(mem_wen), .mem_load(mem_load),
      .stall(stall)
   );

   assign hold_pc_ifid = stall;
   assign flush_idex   = stall;
endmodule

// File: rtl/hzu_chk.sv
module hzu_chk #(
   parameter int unsigned IDX_W = 5
) (
   input logic [IDX_W-1:0] ex_rs1,
   input logic [IDX_W-1:0] ex_rs2,
   input logic [IDX_W-1:0] mem_rs2,
   input logic             mem_store,
   input logic [IDX_W-1:0] mem_rd,
   input logic             mem_wen,
   input logic             mem_load,
   input logic [IDX_W-1:0] wb_rd,
   input logic             wb_wen,
   input logic [IDX_W-1:0] ex_rd,
   input logic             ex_wen,
   input logic [1:0]       fwd_a_sel,
   input logic [1:0]       fwd_b_sel,
   input logic             st_data_sel,
   input logic [1:0]       zero_sel,
   input logic             hold_pc_ifid,
   input logic             flush_idex
);
   always_comb begin
      // R4
      a_zero_idx_chk: assert (fwd_a_sel == 2'd0 || ex_rs1 != '0);
      // R4
      b_zero_idx_chk: assert (fwd_b_sel == 2'd0 || ex_rs2 != '0);
      // R1
      a_near_src_chk: assert (fwd_a_sel != 2'd1 || (mem_wen && mem_rd == ex_rs1));
      // R1
      b_near_src_chk: assert (fwd_b_sel != 2'd1 || (mem_wen && mem_rd == ex_rs2));
      // R2
      a_far_src_chk: assert (fwd_a_sel != 2'd2 || (wb_wen && wb_rd == ex_rs1));
      // R2
      sel_code_chk: assert (fwd_a_sel != 2'd3 && fwd_b_sel != 2'd3 && zero_sel != 2'd3);
      // R5
      st_src_chk: assert (!st_data_sel || (mem_store && wb_wen && wb_rd == mem_rs2));
      // R6
      zero_no_load_chk: assert (zero_sel != 2'd1 || !mem_load);
      // R8
      stall_cause_chk: assert (!hold_pc_ifid || ex_wen || (mem_wen && mem_load));
      // R10
      hold_flush_chk: assert (hold_pc_ifid == flush_idex);
   end
   logic unused_chk;
   assign unused_chk = ^ex_rd;
endmodule

bind hazard_bypass_unit hzu_chk #(.IDX_W(IDX_W)) u_chk (.*);

// File: tb/hazard_bypass_unit_bench.sv
module hazard_bypass_unit_bench;
   localparam int W = 5;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic [W-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rs2, mem_rd, wb_rd;
   logic id_use_a, id_use_b, id_store, id_branch;
   logic ex_use_a, ex_use_b, ex_wen, ex_load;
   logic mem_store, mem_wen, mem_load, wb_wen;
   logic [1:0] fwd_a_sel, fwd_b_sel, zero_sel;
   logic st_data_sel, hold_pc_ifid, flush_idex;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   hazard_bypass_unit #(.IDX_W(W)) u_hazard_bypass_unit (.*);

   task automatic clr();
      id_rs1 = '0; id_rs2 = '0; id_use_a = 0; id_use_b = 0; id_store = 0; id_branch = 0;
      ex_rs1 = '0; ex_rs2 = '0; ex_use_a = 0; ex_use_b = 0; ex_rd = '0; ex_wen = 0; ex_load = 0;
      mem_rs2 = '0; mem_store = 0; mem_rd = '0; mem_wen = 0; mem_load = 0;
      wb_rd = '0; wb_wen = 0;
   endtask

   task automatic settle();
      @(negedge clk);
   endtask

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic chk_stall(string req, int exp);
      chk(req, hold_pc_ifid, exp);
      chk({req, " flush"}, flush_idex, exp);
   endtask

   task automatic t_idle();
      clr(); settle();
      chk("R2 idle a", fwd_a_sel, 0);
      chk("R2 idle b", fwd_b_sel, 0);
      chk("R5 idle st", st_data_sel, 0);
      chk("R6 idle zero", zero_sel, 0);
      chk_stall("R10 idle", 0);
   endtask

   task automatic t_near();
      clr(); ex_rs1 = 3; ex_use_a = 1; ex_rs2 = 7; ex_use_b = 1;
      mem_rd = 3; mem_wen = 1; settle();
      chk("R1 a near", fwd_a_sel, 1);
      chk("R1 b unmatched", fwd_b_sel, 0);
      mem_rd = 7; settle();
      chk("R1 b near", fwd_b_sel, 1);
      chk("R1 a now file", fwd_a_sel, 0);
   endtask

   task automatic t_far();
      clr(); ex_rs1 = 5; ex_use_a = 1; wb_rd = 5; wb_wen = 1; settle();
      chk("R2 a far", fwd_a_sel, 2);
      ex_rs2 = 5; ex_use_b = 1; mem_rd = 6; mem_wen = 1; settle();
      chk("R2 b far", fwd_b_sel, 2);
   endtask

   task automatic t_prio();
      clr(); ex_rs1 = 9; ex_use_a = 1; mem_rd = 9; mem_wen = 1; wb_rd = 9; wb_wen = 1; settle();
      chk("R3 younger wins", fwd_a_sel, 1);
   endtask

   task automatic t_zero_idx();
      clr(); ex_rs1 = 0; ex_use_a = 1; mem_rd = 0; mem_wen = 1; wb_rd = 0; wb_wen = 1; settle();
      chk("R4 reg0 no fwd", fwd_a_sel, 0);
      clr(); ex_rs1 = 4; ex_use_a = 1; mem_rd = 4; mem_wen = 0; settle();
      chk("R4 no wen", fwd_a_sel, 0);
      clr(); ex_rs2 = 4; ex_use_b = 0; mem_rd = 4; mem_wen = 1; settle();
      chk("R4 unused src", fwd_b_sel, 0);
      clr(); id_rs1 = 0; id_use_a = 1; ex_rd = 0; ex_wen = 1; ex_load = 1; settle();
      chk_stall("R4 reg0 no stall", 0);
   endtask

   task automatic t_store();
      clr(); mem_store = 1; mem_rs2 = 4; wb_rd = 4; wb_wen = 1; settle();
      chk("R5 st fwd", st_data_sel, 1);
      wb_rd = 5; settle();
      chk("R5 st mismatch", st_data_sel, 0);
      clr(); id_store = 1; id_use_b = 1; id_rs2 = 11; ex_rd = 11; ex_wen = 1; ex_load = 1; settle();
      chk_stall("R5 load then store", 0);
   endtask

   task automatic t_branch_fwd();
      clr(); id_branch = 1; id_rs1 = 6; mem_rd = 6; mem_wen = 1; settle();
      chk("R6 zero near", zero_sel, 1);
      chk_stall("R6 no stall", 0);
      mem_rd = 1; wb_rd = 6; wb_wen = 1; settle();
      chk("R6 zero far", zero_sel, 2);
   endtask

   task automatic t_load_use();
      clr(); id_rs1 = 2; id_use_a = 1; ex_rd = 2; ex_wen = 1; ex_load = 1; settle();
      chk_stall("R7 load use a", 1);
      clr(); id_rs2 = 12; id_use_b = 1; ex_rd = 12; ex_wen = 1; ex_load = 1; settle();
      chk_stall("R7 load use b", 1);
      clr(); id_rs1 = 2; id_use_a = 1; ex_rd = 2; ex_wen = 1; ex_load = 0; settle();
      chk_stall("R9 alu producer", 0);
   endtask

   task automatic t_branch_stall();
      clr(); id_branch = 1; id_rs1 = 8; ex_rd = 8; ex_wen = 1; settle();
      chk_stall("R8 branch vs ex", 1);
      clr(); id_branch = 1; id_rs1 = 8; mem_rd = 8; mem_wen = 1; mem_load = 1; settle();
      chk_stall("R8 branch vs mem load", 1);
      chk("R6 zero not from load", zero_sel, 0);
      clr(); id_branch = 0; id_rs1 = 8; ex_rd = 8; ex_wen = 1; settle();
      chk_stall("R9 no branch no use", 0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got 0 expected 1");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      clr();
      repeat (2) @(posedge clk);
      t_idle();
      t_near();
      t_far();
      t_prio();
      t_zero_idx();
      t_store();
      t_branch_fwd();
      t_load_use();
      t_branch_stall();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule